// File: doc/BRIEF.md
# Wavefront Instruction Fetch Scheduler

This block chooses, one request at a time, which of several hardware wavefront slots may next send an instruction-fetch request toward the instruction cache. Each slot reports whether it is running, how many instructions its buffer holds, whether a branch sits in that buffer, its program counter, its code base address and the byte total of the instructions it has already buffered. A slot that can take more instructions and holds no branch joins an arrival-ordered ready queue. The oldest queued slot is then turned into a request carrying a byte address, a byte count and the slot number. Because a slot with a buffered branch is never queued, no fetch is ever speculative.

The fetch address skips past what the slot has already buffered. The byte count is trimmed so that the request never crosses a cache-line boundary. Requests leave over a valid/ready handshake. A refused request is held unchanged until the port takes it. Each slot keeps a pending mark from the moment it is chosen until a fetch-return pulse naming that slot arrives, so a slot never has two fetches in flight.

Top module: `wave_fetch_sched`

## Requirements
- R1: After reset `reqValid` is low, no slot is queued and no slot has a fetch pending.
- R2: A slot is eligible only while `slotRunning` is 1, its occupancy field is at most 4 (4 itself is eligible, 5 is not), its `slotBranch` bit is 0 and it has no fetch pending.
- R3: An eligible slot enters the ready queue only if it is not already queued, so a slot that stays eligible for many cycles is issued once.
- R4: Queued slots are issued oldest first. Slots that become eligible in the same cycle are queued in rising slot-number order.
- R5: No request is presented while the ready queue is empty.
- R6: Issuing a slot marks it pending and removes it from the queue. A pending slot is not queued again until a cycle with `retValid` high and `retSlot` equal to its number. It can then be issued again two cycles later.
- R7: `reqAddr` equals the slot's base plus its PC plus its buffered byte total, modulo 2^48, with all three taken in the cycle the slot is chosen.
- R8: `reqSize` is 64 minus (`reqAddr` mod 64). It is therefore 64 for a line-aligned address, and otherwise the distance to the next 64-byte boundary.
- R9: While `reqValid` is high and `reqReady` is low, `reqAddr`, `reqSize` and `reqSlot` stay unchanged and no other slot is issued. In the cycle the request is accepted, the next queued slot may be loaded.
- R10: With an empty queue and an idle port, a slot that becomes eligible before clock edge k shows on the request port after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slotRunning | input | NUM_SLOTS | Per-slot running status |
| slotBranch | input | NUM_SLOTS | Per-slot flag: a branch is in the buffer |
| slotOcc | input | NUM_SLOTS*OCC_W | Per-slot buffer occupancy in instructions, slot i at bits [i*OCC_W +: OCC_W] |
| slotPc | input | NUM_SLOTS*ADDR_W | Per-slot program counter, slot i at [i*ADDR_W +: ADDR_W] |
| slotBase | input | NUM_SLOTS*ADDR_W | Per-slot code base address |
| slotBufBytes | input | NUM_SLOTS*BUFB_W | Per-slot byte total of the buffered instructions |
| retValid | input | 1 | Fetch-return pulse |
| retSlot | input | SLOT_W | Slot whose fetch returned |
| reqValid | output | 1 | Fetch request valid |
| reqReady | input | 1 | Downstream accepts the request |
| reqAddr | output | ADDR_W | Fetch byte address |
| reqSize | output | SIZE_W | Fetch byte count, 1 to line size |
| reqSlot | output | SLOT_W | Slot the request belongs to |

## Verification
The address and size datapath is driven from a vector table. The table covers a line-aligned address, addresses a few bytes and one byte short of a boundary, an address that wraps past 2^48, and a non-zero buffered byte total. Together these separate a correct sum and trim from one that drops a term or ignores the line offset. The same table places each slot on the edge of eligibility (occupancy 4 against 5, a branch present, not running), which tells the occupancy comparison apart from an off-by-one. Directed sequences stagger arrivals across cycles and hold the port refused, which exposes wrong queue order, a request that changes while refused, and double queuing. Simultaneous arrivals check the tie order. A fetch-return pulse for one of several pending slots shows that only the named slot is released.

// File: rtl/wfs_pkg.sv
package wfs_pkg;
  localparam int unsigned WFS_SLOTS      = 8;
  localparam int unsigned WFS_LINE_BYTES = 64;
  localparam int unsigned WFS_ADDR_W     = 48;
  localparam int unsigned WFS_OCC_W      = 4;
  localparam int unsigned WFS_MAX_OCC    = 4;
  localparam int unsigned WFS_BUFB_W     = 8;
  localparam int unsigned WFS_SLOT_W     = $clog2(WFS_SLOTS);
  localparam int unsigned WFS_SIZE_W     = $clog2(WFS_LINE_BYTES) + 1;

  // strobes from control to datapath
  typedef struct packed {
    logic                  load;  // capture a new request this cycle
    logic [WFS_SLOT_W-1:0] slot;  // slot being issued
  } wfs_strobe_t;
endpackage

// File: rtl/wfs_ctrl.sv
module wfs_ctrl
  import wfs_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = WFS_SLOTS,
  parameter int unsigned OCC_W     = WFS_OCC_W,
  parameter int unsigned MAX_OCC   = WFS_MAX_OCC,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS),
  localparam int unsigned CNT_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_SLOTS-1:0]       slotRunning,
  input  logic [NUM_SLOTS-1:0]       slotBranch,
  input  logic [NUM_SLOTS*OCC_W-1:0] slotOcc,
  input  logic                       retValid,
  input  logic [SLOT_W-1:0]          retSlot,
  input  logic                       reqReady,
  output logic                       reqValid,
  output wfs_strobe_t                strobe
);
  logic [NUM_SLOTS-1:0] pendingQ;
  logic [NUM_SLOTS-1:0] queuedQ;
  logic [SLOT_W-1:0]    fifoMem [NUM_SLOTS];
  logic [SLOT_W-1:0]    headQ;
  logic [CNT_W-1:0]     countQ;
  logic                 reqValidQ;

  logic [NUM_SLOTS-1:0] eligible;
  logic [NUM_SLOTS-1:0] pushVec;
  logic [SLOT_W-1:0]    pushPos [NUM_SLOTS];
  logic [CNT_W-1:0]     pushCount;
  logic                 canIssue;
  logic                 doPop;
  logic [SLOT_W-1:0]    headSlot;

  // per-slot eligibility test
  for (genvar gi = 0; gi < NUM_SLOTS; gi++) begin : g_elig
    assign eligible[gi] = slotRunning[gi] && !slotBranch[gi] && !pendingQ[gi] &&
                          (slotOcc[gi*OCC_W +: OCC_W] <= OCC_W'(MAX_OCC));
    assign pushVec[gi]  = eligible[gi] && !queuedQ[gi];
  end

  // queue positions for this cycle's arrivals, lower slot number first
  always_comb begin
    int rank;
    rank = 0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      pushPos[i] = SLOT_W'((int'(headQ) + int'(countQ) + rank) % NUM_SLOTS);
      if (pushVec[i]) rank = rank + 1;
    end
    pushCount = CNT_W'(rank);
  end

  assign canIssue = !reqValidQ || reqReady;
  assign doPop    = canIssue && (countQ != '0);
  assign headSlot = fifoMem[headQ];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendingQ  <= '0;
      queuedQ   <= '0;
      headQ     <= '0;
      countQ    <= '0;
      reqValidQ <= 1'b0;
      for (int i = 0; i < NUM_SLOTS; i++) fifoMem[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (pushVec[i]) begin
          fifoMem[pushPos[i]] <= SLOT_W'(i);
          queuedQ[i]          <= 1'b1;
        end
      end
      if (retValid) pendingQ[retSlot] <= 1'b0;
      if (doPop) begin
        pendingQ[headSlot] <= 1'b1;
        queuedQ[headSlot]  <= 1'b0;
        headQ              <= SLOT_W'((int'(headQ) + 1) % NUM_SLOTS);
      end
      countQ <= countQ + pushCount - CNT_W'(doPop);
      if (canIssue) reqValidQ <= doPop;
    end
  end

  assign reqValid    = reqValidQ;
  assign strobe.load = doPop;
  assign strobe.slot = headSlot;
endmodule

// File: rtl/wfs_datapath.sv
module wfs_datapath
  import wfs_pkg::*;
#(
  parameter int unsigned NUM_SLOTS  = WFS_SLOTS,
  parameter int unsigned ADDR_W     = WFS_ADDR_W,
  parameter int unsigned BUFB_W     = WFS_BUFB_W,
  parameter int unsigned LINE_BYTES = WFS_LINE_BYTES,
  localparam int unsigned SLOT_W    = $clog2(NUM_SLOTS),
  localparam int unsigned OFF_W     = $clog2(LINE_BYTES),
  localparam int unsigned SIZE_W    = OFF_W + 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  wfs_strobe_t                 strobe,
  input  logic [NUM_SLOTS*ADDR_W-1:0] slotPc,
  input  logic [NUM_SLOTS*ADDR_W-1:0] slotBase,
  input  logic [NUM_SLOTS*BUFB_W-1:0] slotBufBytes,
  output logic [ADDR_W-1:0]           reqAddr,
  output logic [SIZE_W-1:0]           reqSize,
  output logic [SLOT_W-1:0]           reqSlot
);
  logic [ADDR_W-1:0] pcArr   [NUM_SLOTS];
  logic [ADDR_W-1:0] baseArr [NUM_SLOTS];
  logic [BUFB_W-1:0] bytesArr[NUM_SLOTS];

  for (genvar gi = 0; gi < NUM_SLOTS; gi++) begin : g_unpack
    assign pcArr[gi]    = slotPc[gi*ADDR_W +: ADDR_W];
    assign baseArr[gi]  = slotBase[gi*ADDR_W +: ADDR_W];
    assign bytesArr[gi] = slotBufBytes[gi*BUFB_W +: BUFB_W];
  end

  logic [ADDR_W-1:0] fetchAddr;
  logic [OFF_W-1:0]  lineOff;
  logic [SIZE_W-1:0] fetchSize;

  assign fetchAddr = baseArr[strobe.slot] + pcArr[strobe.slot] +
                     ADDR_W'(bytesArr[strobe.slot]);
  assign lineOff   = fetchAddr[OFF_W-1:0];
  // aligned: offset 0 gives a full line; otherwise stop at the boundary
  assign fetchSize = SIZE_W'(LINE_BYTES) - SIZE_W'(lineOff);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqAddr <= '0;
      reqSize <= '0;
      reqSlot <= '0;
    end else if (strobe.load) begin
      reqAddr <= fetchAddr;
      reqSize <= fetchSize;
      reqSlot <= strobe.slot;
    end
  end
endmodule

// File: rtl/wave_fetch_sched.sv
module wave_fetch_sched
  import wfs_pkg::*;
#(
  parameter int unsigned NUM_SLOTS  = WFS_SLOTS,
  parameter int unsigned LINE_BYTES = WFS_LINE_BYTES,
  parameter int unsigned ADDR_W     = WFS_ADDR_W,
  parameter int unsigned OCC_W      = WFS_OCC_W,
  parameter int unsigned MAX_OCC    = WFS_MAX_OCC,
  parameter int unsigned BUFB_W     = WFS_BUFB_W,
  localparam int unsigned SLOT_W    = $clog2(NUM_SLOTS),
  localparam int unsigned SIZE_W    = $clog2(LINE_BYTES) + 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_SLOTS-1:0]        slotRunning,
  input  logic [NUM_SLOTS-1:0]        slotBranch,
  input  logic [NUM_SLOTS*OCC_W-1:0]  slotOcc,
  input  logic [NUM_SLOTS*ADDR_W-1:0] slotPc,
  input  logic [NUM_SLOTS*ADDR_W-1:0] slotBase,
  input  logic [NUM_SLOTS*BUFB_W-1:0] slotBufBytes,
  input  logic                        retValid,
  input  logic [SLOT_W-1:0]           retSlot,
  output logic                        reqValid,
  input  logic                        reqReady,
  output logic [ADDR_W-1:0]           reqAddr,
  output logic [SIZE_W-1:0]           reqSize,
  output logic [SLOT_W-1:0]           reqSlot
);
  wfs_strobe_t strobe;

  wfs_ctrl #(
    .NUM_SLOTS(NUM_SLOTS), .OCC_W(OCC_W), .MAX_OCC(MAX_OCC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .slotRunning(slotRunning), .slotBranch(slotBranch),
    .slotOcc(slotOcc), .retValid(retValid), .retSlot(retSlot),
    .reqReady(reqReady), .reqValid(reqValid), .strobe(strobe)
  );

  wfs_datapath #(
    .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .BUFB_W(BUFB_W), .LINE_BYTES(LINE_BYTES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .slotPc(slotPc), .slotBase(slotBase),
    .slotBufBytes(slotBufBytes), .reqAddr(reqAddr), .reqSize(reqSize), .reqSlot(reqSlot)
  );
endmodule

// File: rtl/wfs_checker.sv
module wfs_checker #(
  parameter int unsigned ADDR_W     = 48,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned SLOT_W     = 3,
  localparam int unsigned OFF_W     = $clog2(LINE_BYTES),
  localparam int unsigned SIZE_W    = OFF_W + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [SIZE_W-1:0] reqSize,
  input logic [SLOT_W-1:0] reqSlot,
  input logic              loadStb,
  input logic [SLOT_W-1:0] loadSlot
);
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> (reqValid && $stable(reqAddr) && $stable(reqSize) && $stable(reqSlot))); // R9

  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |-> !loadStb); // R9

  AST_LOAD_SHOWS: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |=> (reqValid && reqSlot == $past(loadSlot))); // R6

  AST_SIZE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqSize != '0 && reqSize <= SIZE_W'(LINE_BYTES))); // R8

  AST_LINE_END: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> ((SIZE_W'(reqAddr[OFF_W-1:0]) + reqSize) == SIZE_W'(LINE_BYTES))); // R8
endmodule

bind wave_fetch_sched wfs_checker #(
  .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .SLOT_W(SLOT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqAddr(reqAddr), .reqSize(reqSize), .reqSlot(reqSlot),
  .loadStb(strobe.load), .loadSlot(strobe.slot)
);

// File: tb/wave_fetch_sched_tb.sv
`timescale 1ns/1ps
module wave_fetch_sched_tb;
  localparam int N  = 8;
  localparam int AW = 48;
  localparam int OW = 4;
  localparam int BW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [N-1:0]  slotRunning = '0;
  logic [N-1:0]  slotBranch = '0;
  logic [N*OW-1:0] slotOcc = '0;
  logic [N*AW-1:0] slotPc = '0;
  logic [N*AW-1:0] slotBase = '0;
  logic [N*BW-1:0] slotBufBytes = '0;
  logic          retValid = 1'b0;
  logic [2:0]    retSlot = '0;
  logic          reqValid;
  logic          reqReady = 1'b0;
  logic [AW-1:0] reqAddr;
  logic [6:0]    reqSize;
  logic [2:0]    reqSlot;

  always #2.5 clk = ~clk;

  wave_fetch_sched u_dut (
    .clk(clk), .rstN(rstN), .slotRunning(slotRunning), .slotBranch(slotBranch),
    .slotOcc(slotOcc), .slotPc(slotPc), .slotBase(slotBase), .slotBufBytes(slotBufBytes),
    .retValid(retValid), .retSlot(retSlot), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqSlot(reqSlot)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setSlot(input int s, input bit run, input logic [3:0] occ, input bit br,
                         input logic [47:0] pc, input logic [47:0] base, input logic [7:0] bytes);
    slotRunning[s]          = run;
    slotBranch[s]           = br;
    slotOcc[s*OW +: OW]     = occ;
    slotPc[s*AW +: AW]      = pc;
    slotBase[s*AW +: AW]    = base;
    slotBufBytes[s*BW +: BW] = bytes;
  endtask

  task automatic clearAll();
    slotRunning = '0; slotBranch = '0; slotOcc = '0;
    slotPc = '0; slotBase = '0; slotBufBytes = '0;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic retire(input int s);
    retValid = 1'b1; retSlot = 3'(s);
    tick();
    retValid = 1'b0;
  endtask

  typedef struct packed {
    logic [2:0]  slot;
    logic        run;
    logic [3:0]  occ;
    logic        br;
    logic [47:0] pc;
    logic [47:0] base;
    logic [7:0]  bytes;
    logic        expV;
    logic [47:0] expAddr;
    logic [6:0]  expSize;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b1, 4'd0, 1'b0, 48'h0,       48'h1000,         8'h00, 1'b1, 48'h1000,         7'd64}, // aligned R7 R8
    '{3'd3, 1'b1, 4'd2, 1'b0, 48'h10,      48'h2000,         8'h08, 1'b1, 48'h2018,         7'd40}, // buffered bytes R7
    '{3'd7, 1'b1, 4'd1, 1'b0, 48'h3C,      48'h100,          8'h00, 1'b1, 48'h13C,          7'd4},  // R8
    '{3'd5, 1'b1, 4'd4, 1'b0, 48'h40,      48'h40,           8'h3F, 1'b1, 48'hBF,           7'd1},  // occ 4 eligible R2
    '{3'd2, 1'b1, 4'd5, 1'b0, 48'h0,       48'h3000,         8'h00, 1'b0, 48'h0,            7'd0},  // occ 5 R2
    '{3'd1, 1'b1, 4'd0, 1'b1, 48'h0,       48'h3000,         8'h00, 1'b0, 48'h0,            7'd0},  // branch R2
    '{3'd6, 1'b0, 4'd0, 1'b0, 48'h0,       48'h3000,         8'h00, 1'b0, 48'h0,            7'd0},  // not running R2
    '{3'd4, 1'b1, 4'd3, 1'b0, 48'h10000,   48'h800000000000, 8'h20, 1'b1, 48'h800000010020, 7'd32},
    '{3'd0, 1'b1, 4'd0, 1'b0, 48'h8,       48'hFFFFFFFFFFF0, 8'h10, 1'b1, 48'h8,            7'd56}  // wrap R7
  };

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    check(reqValid == 1'b0, "R1 reset valid", 64'(reqValid), 0);
    tick(); tick();
    check(reqValid == 1'b0, "R5 empty queue", 64'(reqValid), 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      setSlot(VECS[v].slot, VECS[v].run, VECS[v].occ, VECS[v].br,
              VECS[v].pc, VECS[v].base, VECS[v].bytes);
      tick(); tick();
      if (VECS[v].expV) begin
        check(reqValid == 1'b1, "R10 request latency", 64'(reqValid), 1);
        check(reqSlot == VECS[v].slot, "R10 slot", 64'(reqSlot), 64'(VECS[v].slot));
        check(reqAddr == VECS[v].expAddr, "R7 address", 64'(reqAddr), 64'(VECS[v].expAddr));
        check(reqSize == VECS[v].expSize, "R8 size", 64'(reqSize), 64'(VECS[v].expSize));
        reqReady = 1'b1;
        tick();
        reqReady = 1'b0;
        check(reqValid == 1'b0, "R5 after accept", 64'(reqValid), 0);
        clearAll();
        retire(VECS[v].slot);
      end else begin
        tick();
        check(reqValid == 1'b0, "R2 ineligible slot", 64'(reqValid), 0);
        clearAll();
      end
    end

    // staggered arrivals with refused port: R4, R9, R3
    clearAll(); tick();
    setSlot(5, 1, 0, 0, 48'h0, 48'h500, 8'h0);
    tick();
    setSlot(2, 1, 0, 0, 48'h0, 48'h200, 8'h0);
    tick();
    check(reqValid && reqSlot == 3'd5, "R4 first issued", 64'(reqSlot), 5);
    setSlot(6, 1, 0, 0, 48'h0, 48'h600, 8'h0);
    for (int k = 0; k < 3; k++) begin
      tick();
      check(reqValid && reqSlot == 3'd5 && reqAddr == 48'h500, "R9 held while refused", 64'(reqAddr), 64'h500);
    end
    reqReady = 1'b1;
    tick();
    check(reqValid && reqSlot == 3'd2 && reqAddr == 48'h200, "R4 second in order", 64'(reqSlot), 2);
    tick();
    check(reqValid && reqSlot == 3'd6, "R4 third in order", 64'(reqSlot), 6);
    tick();
    check(reqValid == 1'b0, "R3 no duplicate entry", 64'(reqValid), 0);
    reqReady = 1'b0;
    for (int k = 0; k < 4; k++) begin
      tick();
      check(reqValid == 1'b0, "R6 pending blocks reissue", 64'(reqValid), 0);
    end

    // return for slot 2 only
    retire(2);
    check(reqValid == 1'b0, "R6 return edge", 64'(reqValid), 0);
    tick();
    check(reqValid == 1'b0, "R6 requeue cycle", 64'(reqValid), 0);
    tick();
    check(reqValid && reqSlot == 3'd2, "R6 reissue after return", 64'(reqSlot), 2);
    reqReady = 1'b1;
    tick();
    reqReady = 1'b0;
    check(reqValid == 1'b0, "R6 only named slot released", 64'(reqValid), 0);
    clearAll();
    retire(5); retire(2); retire(6);

    // simultaneous arrivals: R4 tie order
    reqReady = 1'b1;
    setSlot(3, 1, 0, 0, 48'h0, 48'h300, 8'h0);
    setSlot(1, 1, 0, 0, 48'h0, 48'h100, 8'h0);
    tick(); tick();
    check(reqValid && reqSlot == 3'd1, "R4 tie lower first", 64'(reqSlot), 1);
    tick();
    check(reqValid && reqSlot == 3'd3, "R4 tie higher second", 64'(reqSlot), 3);
    tick();
    check(reqValid == 1'b0, "R5 drained", 64'(reqValid), 0);
    reqReady = 1'b0;
    clearAll();

    // reset clears pending: R1
    setSlot(0, 1, 0, 0, 48'h40, 48'h0, 8'h0);
    rstN = 1'b0;
    tick();
    rstN = 1'b1;
    check(reqValid == 1'b0, "R1 valid low after reset", 64'(reqValid), 0);
    tick(); tick();
    check(reqValid && reqSlot == 3'd0 && reqSize == 7'd64, "R1 pending cleared by reset", 64'(reqSlot), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule